// File: doc/BRIEF.md
# Bunch-Train Hit Capture Controller

This block is the digital control for one readout channel of a pixel detector that runs through a collider bunch train. A bunch counter follows the bunch clock for the whole train. When the channel's event comparator fires, the bunch number and the gain-range bit are stored in the next free slot of a small store that is fixed at four entries. No conversion happens while the train is running.

When the train ends, the block converts each filled slot in turn. Conversion is a Wilkinson count: the block raises a busy flag that starts the analog ramp for the selected slot. A counter then runs until the ramp comparator trips. Each converted slot leaves the block as one record on a valid/ready stream. Empty slots produce no record, so a quiet channel sends nothing.

Top module: `train_hit_capture`

## Requirements
- R1: After a synchronous reset, `rec_valid_o` and `conv_busy_o` are both low.
- R2: A `train_start_i` pulse clears the bunch counter to 0, the fill count and all slot-valid flags, and drops any record or conversion in progress. An event that arrives in the same cycle as the pulse is not stored.
- R3: The bunch counter is 12 bits wide. It steps by one on each `bunch_tick_i` and stays at 4095 once it reaches 4095. An event in a tick cycle belongs to the new bunch.
- R4: While the train is open, a high `event_cmp_i` stores the current bunch number and the `range_cmp_i` level in the next free slot. The range level is 1 for low gain and 0 for high gain, and high gain is the default.
- R5: At most one event is stored per bunch period. A comparator held high for several clocks stores one event. If it is still high after the next tick, it stores a new event for the new bunch.
- R6: Once four events are stored, further events in that train are ignored. Events in the `train_end_i` cycle or after it are also ignored.
- R7: Conversion starts in the cycle after the `train_end_i` edge and treats the slots in ascending order. `conv_busy_o` is high and `conv_slot_o` names the slot. If `ramp_cmp_i` is first high on busy cycle k, counting from 0, the charge count is k. `rec_valid_o` stays low while `conv_busy_o` is high.
- R8: If the ramp comparator never trips, the count stops at 8191 and `rec_ovf_o` is set for that record. A trip on busy cycle 8191 gives 8191 with no overflow.
- R9: A record is laid out as `rec_data_o[27:26]` = slot index, `[25]` = range bit, `[24:13]` = bunch number and `[12:0]` = charge count.
- R10: Only filled slots produce records. A train with no stored event produces no record.
- R11: While `rec_valid_o` is high and `rec_ready_i` is low, the record stays valid and `rec_data_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bunch_tick_i | input | 1 | One-cycle pulse at each new bunch crossing |
| train_start_i | input | 1 | Opens a train and clears all capture state |
| train_end_i | input | 1 | Closes the train and starts readout |
| event_cmp_i | input | 1 | Event-threshold comparator output |
| range_cmp_i | input | 1 | Range-threshold comparator output (1 = low gain) |
| ramp_cmp_i | input | 1 | Wilkinson ramp comparator output |
| conv_busy_o | output | 1 | Ramp enable for the slot being converted |
| conv_slot_o | output | 2 | Slot under conversion |
| rec_valid_o | output | 1 | Record valid |
| rec_ready_i | input | 1 | Record accepted by the consumer |
| rec_data_o | output | 28 | Record {slot, range, bunch, charge} |
| rec_ovf_o | output | 1 | Charge count saturated without a trip |

## Verification
A stored event enters the fill count one cycle after the clock edge that sampled it. The first conversion cycle follows the edge that took `train_end_i`. The charge count equals the busy-cycle index on which the ramp comparator is presented, and the record becomes valid on the edge that sees the trip. The bench plays the ramp as an analog model: on each falling edge of a busy cycle it compares its own busy-cycle count with the chosen charge for `conv_slot_o`. It compares every record at the falling edge before the rising edge that transfers it. After each train it idles long enough to catch any record that should not appear.

// File: rtl/hitcap_pkg.sv
package hitcap_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRAIN = 2'd1,
    PH_CONV  = 2'd2,
    PH_EMIT  = 2'd3
  } phase_t;
endpackage

// File: rtl/hc_bunch_timer.sv
// Bunch-crossing counter with a per-bunch capture lock.
module hc_bunch_timer #(
  parameter int BUNCH_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               tick,
  input  logic               mark,
  output logic [BUNCH_W-1:0] bunch_now,
  output logic               bunch_open
);
  localparam logic [BUNCH_W-1:0] BUNCH_MAX = '1;

  logic [BUNCH_W-1:0] cnt_q;
  logic [BUNCH_W-1:0] cnt_inc;
  logic               lock_q;

  // saturating step
  always_comb cnt_inc = (cnt_q == BUNCH_MAX) ? cnt_q : cnt_q + 1'b1;

  // a tick cycle already belongs to the new bunch
  always_comb begin
    bunch_now  = tick ? cnt_inc : cnt_q;
    bunch_open = tick | ~lock_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (tick) cnt_q <= cnt_inc;
      lock_q <= mark | (lock_q & ~tick);
    end
  end
endmodule

// File: rtl/hc_hit_store.sv
// Fixed-depth sample store: bunch number plus range bit per slot.
module hc_hit_store #(
  parameter int SLOTS   = 4,
  parameter int BUNCH_W = 12,
  parameter int SW      = $clog2(SLOTS),
  parameter int CW      = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               wr_en,
  input  logic               wr_range,
  input  logic [BUNCH_W-1:0] wr_bunch,
  input  logic [SW-1:0]      rd_slot,
  output logic               rd_range,
  output logic [BUNCH_W-1:0] rd_bunch,
  output logic [SLOTS-1:0]   slot_vld,
  output logic [CW-1:0]      fill,
  output logic               full
);
  localparam int ENT_W = BUNCH_W + 1;

  logic [ENT_W-1:0] mem [SLOTS];
  logic [CW-1:0]    fill_q;
  logic [SW-1:0]    wr_ptr;
  logic             we;

  always_comb begin
    full   = (fill_q == CW'(SLOTS));
    wr_ptr = fill_q[SW-1:0];
    we     = wr_en & ~full & ~clear;
    fill   = fill_q;
  end

  // small distributed RAM, no reset on contents
  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= {wr_range, wr_bunch};
  end

  always_comb {rd_range, rd_bunch} = mem[rd_slot];

  always_ff @(posedge clk) begin
    if (rst || clear) fill_q <= '0;
    else if (we)      fill_q <= fill_q + 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst || clear)                slot_vld[g] <= 1'b0;
      else if (we && wr_ptr == SW'(g)) slot_vld[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/hc_wilkinson.sv
// Run-until-trip counter with saturation.
module hc_wilkinson #(
  parameter int ADC_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             trip,
  output logic [ADC_W-1:0] count,
  output logic             done,
  output logic             ovf
);
  localparam logic [ADC_W-1:0] ADC_MAX = '1;

  logic [ADC_W-1:0] cnt_q;
  logic             at_max;

  always_comb begin
    at_max = (cnt_q == ADC_MAX);
    done   = run & (trip | at_max);
    ovf    = run & ~trip & at_max;
    count  = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/train_hit_capture.sv
module train_hit_capture
  import hitcap_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int BUNCH_W = 12,
  parameter int ADC_W   = 13
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  bunch_tick_i,
  input  logic                                  train_start_i,
  input  logic                                  train_end_i,
  input  logic                                  event_cmp_i,
  input  logic                                  range_cmp_i,
  input  logic                                  ramp_cmp_i,
  output logic                                  conv_busy_o,
  output logic [$clog2(SLOTS)-1:0]              conv_slot_o,
  output logic                                  rec_valid_o,
  input  logic                                  rec_ready_i,
  output logic [$clog2(SLOTS)+BUNCH_W+ADC_W:0]  rec_data_o,
  output logic                                  rec_ovf_o
);
  localparam int SW    = $clog2(SLOTS);
  localparam int CW    = $clog2(SLOTS + 1);
  localparam int REC_W = SW + 1 + BUNCH_W + ADC_W;
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  phase_t             phase_q;
  logic [SW-1:0]      rd_slot_q;
  logic [SW-1:0]      next_slot;
  logic               rec_valid_q;
  logic [REC_W-1:0]   rec_data_q;
  logic               rec_ovf_q;

  logic [BUNCH_W-1:0] bunch_now;
  logic               bunch_open;
  logic               capture;
  logic               rd_range;
  logic [BUNCH_W-1:0] rd_bunch;
  logic [SLOTS-1:0]   slot_vld;
  logic [CW-1:0]      fill;
  logic               full;
  logic               conv_run;
  logic [ADC_W-1:0]   adc_count;
  logic               adc_done;
  logic               adc_ovf;
  logic               more_slots;

  always_comb begin
    capture = (phase_q == PH_TRAIN) & ~train_start_i & ~train_end_i &
              event_cmp_i & bunch_open & ~full;
    conv_run   = (phase_q == PH_CONV);
    next_slot  = rd_slot_q + 1'b1;
    more_slots = (rd_slot_q != LAST_SLOT) & slot_vld[next_slot];
  end

  hc_bunch_timer #(.BUNCH_W(BUNCH_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .clear      (train_start_i),
    .tick       (bunch_tick_i),
    .mark       (capture),
    .bunch_now  (bunch_now),
    .bunch_open (bunch_open)
  );

  hc_hit_store #(.SLOTS(SLOTS), .BUNCH_W(BUNCH_W), .SW(SW), .CW(CW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clear    (train_start_i),
    .wr_en    (capture),
    .wr_range (range_cmp_i),
    .wr_bunch (bunch_now),
    .rd_slot  (rd_slot_q),
    .rd_range (rd_range),
    .rd_bunch (rd_bunch),
    .slot_vld (slot_vld),
    .fill     (fill),
    .full     (full)
  );

  hc_wilkinson #(.ADC_W(ADC_W)) u_wilk (
    .clk   (clk),
    .rst   (rst),
    .run   (conv_run),
    .trip  (ramp_cmp_i),
    .count (adc_count),
    .done  (adc_done),
    .ovf   (adc_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      rd_slot_q   <= '0;
      rec_valid_q <= 1'b0;
      rec_data_q  <= '0;
      rec_ovf_q   <= 1'b0;
    end else if (train_start_i) begin
      phase_q     <= PH_TRAIN;
      rd_slot_q   <= '0;
      rec_valid_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_TRAIN: begin
          if (train_end_i) begin
            rd_slot_q <= '0;
            phase_q   <= slot_vld[0] ? PH_CONV : PH_IDLE;
          end
        end
        PH_CONV: begin
          if (adc_done) begin
            rec_data_q  <= {rd_slot_q, rd_range, rd_bunch, adc_count};
            rec_ovf_q   <= adc_ovf;
            rec_valid_q <= 1'b1;
            phase_q     <= PH_EMIT;
          end
        end
        PH_EMIT: begin
          if (rec_ready_i) begin
            rec_valid_q <= 1'b0;
            if (more_slots) begin
              rd_slot_q <= next_slot;
              phase_q   <= PH_CONV;
            end else begin
              phase_q   <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    conv_busy_o = conv_run;
    conv_slot_o = rd_slot_q;
    rec_valid_o = rec_valid_q;
    rec_data_o  = rec_data_q;
    rec_ovf_o   = rec_ovf_q;
  end
endmodule

// File: rtl/hc_checker.sv
module hc_checker #(
  parameter int SLOTS   = 4,
  parameter int BUNCH_W = 12,
  parameter int ADC_W   = 13,
  parameter int CW      = $clog2(SLOTS + 1),
  parameter int REC_W   = $clog2(SLOTS) + 1 + BUNCH_W + ADC_W
) (
  input logic             clk,
  input logic             rst,
  input logic             train_start_i,
  input logic             bunch_tick_i,
  input logic             capture,
  input logic [CW-1:0]    fill,
  input logic             conv_busy_o,
  input logic             rec_valid_o,
  input logic             rec_ready_i,
  input logic [REC_W-1:0] rec_data_o,
  input logic             rec_ovf_o
);
  localparam logic [ADC_W-1:0] ADC_MAX = '1;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    train_start_i |=> (fill == '0) && !rec_valid_o && !conv_busy_o); // R2

  AST_ONE_PER_BUNCH: assert property (@(posedge clk) disable iff (rst)
    capture |=> !(capture && !bunch_tick_i)); // R5

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fill == CW'(SLOTS)) && !train_start_i |=> fill == CW'(SLOTS)); // R6

  AST_QUIET_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    conv_busy_o |-> !rec_valid_o); // R7

  AST_OVF_SATURATED: assert property (@(posedge clk) disable iff (rst)
    rec_valid_o && rec_ovf_o |-> rec_data_o[ADC_W-1:0] == ADC_MAX); // R8

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
    rec_valid_o && !rec_ready_i && !train_start_i |=>
      rec_valid_o && $stable(rec_data_o)); // R11
endmodule

bind train_hit_capture hc_checker u_hc_checker (
  .clk           (clk),
  .rst           (rst),
  .train_start_i (train_start_i),
  .bunch_tick_i  (bunch_tick_i),
  .capture       (capture),
  .fill          (fill),
  .conv_busy_o   (conv_busy_o),
  .rec_valid_o   (rec_valid_o),
  .rec_ready_i   (rec_ready_i),
  .rec_data_o    (rec_data_o),
  .rec_ovf_o     (rec_ovf_o)
);

// File: tb/test_train_hit_capture.sv
`timescale 1ns/1ps
module test_train_hit_capture;
  typedef struct {
    logic [27:0] data;
    logic        ovf;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bunch_tick = 1'b0, train_start = 1'b0, train_end = 1'b0;
  logic        event_cmp = 1'b0, range_cmp = 1'b0, ramp_cmp = 1'b0;
  logic        rec_ready = 1'b0;
  logic        conv_busy_o, rec_valid_o, rec_ovf_o;
  logic [1:0]  conv_slot_o;
  logic [27:0] rec_data_o;

  int errors = 0, checks = 0, cyc = 0, ncyc = 0, rec_count = 0;
  int tgt[4];
  int ramp_k = 0;
  exp_t sb[$];
  string cur_tag = "";
  int  m_bn = 0, m_cnt = 0;
  bit  m_lock = 0, m_train = 0;
  bit  prev_stall = 0;
  logic [27:0] prev_data = '0;

  always #2 clk = ~clk;

  train_hit_capture i_train_hit_capture (
    .clk(clk), .rst(rst), .bunch_tick_i(bunch_tick), .train_start_i(train_start),
    .train_end_i(train_end), .event_cmp_i(event_cmp), .range_cmp_i(range_cmp),
    .ramp_cmp_i(ramp_cmp), .conv_busy_o(conv_busy_o), .conv_slot_o(conv_slot_o),
    .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready), .rec_data_o(rec_data_o),
    .rec_ovf_o(rec_ovf_o)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // driver: sets inputs for one cycle and updates the reference model
  task automatic drive(input logic tk, input logic ev, input logic rg, input logic st, input logic en);
    @(negedge clk);
    bunch_tick = tk; event_cmp = ev; range_cmp = rg; train_start = st; train_end = en;
    if (st) begin
      sb.delete(); m_bn = 0; m_lock = 0; m_cnt = 0; m_train = 1;
    end else begin
      if (tk) begin
        if (m_bn != 4095) m_bn++;
        m_lock = 0;
      end
      if (m_train && ev && !en && !m_lock && m_cnt < 4) begin
        exp_t e;
        int a;
        a = (tgt[m_cnt] > 8191) ? 8191 : tgt[m_cnt];
        e.data = {2'(m_cnt), rg, 12'(m_bn), 13'(a)};
        e.ovf  = (tgt[m_cnt] > 8191);
        e.tag  = e.ovf ? "R8" : cur_tag;
        sb.push_back(e);
        m_lock = 1;
        m_cnt++;
      end
      if (en) m_train = 0;
    end
  endtask

  task automatic bunch(input logic tk, input int from, input int len, input logic rg);
    for (int c = 0; c < 4; c++)
      drive(tk && c == 0, (c >= from) && (c < from + len), rg, 1'b0, 1'b0);
  endtask

  task automatic drain(input string req);
    int w = 0;
    drive(0, 0, 0, 0, 0);
    while (!(sb.size() == 0 && !conv_busy_o && !rec_valid_o) && w < 20000) begin
      @(negedge clk); w++;
    end
    repeat (12) @(negedge clk);
    check(sb.size() == 0, {req, " pending expected records"}, sb.size(), 0);
  endtask

  // ramp comparator model: trips on busy cycle number tgt[slot]
  always @(negedge clk) begin
    if (conv_busy_o) begin
      ramp_cmp = (ramp_k == tgt[conv_slot_o]);
      ramp_k++;
    end else begin
      ramp_cmp = 1'b0;
      ramp_k = 0;
    end
  end

  // monitor: backpressure, hold check and scoreboard compare
  always @(negedge clk) begin
    ncyc++;
    if (prev_stall)
      check(rec_valid_o && rec_data_o == prev_data, "R11 record held under backpressure",
            {3'b0, rec_valid_o, rec_data_o}, {4'b1, prev_data});
    rec_ready = (ncyc % 3) != 1;
    if (!rst && rec_valid_o && rec_ready) begin
      rec_count++;
      if (sb.size() == 0) begin
        check(0, "R10 unexpected record", {4'b0, rec_data_o}, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rec_data_o == e.data && rec_ovf_o == e.ovf, {e.tag, " record"},
              {3'b0, rec_ovf_o, rec_data_o}, {3'b0, e.ovf, e.data});
      end
    end
    prev_stall = !rst && rec_valid_o && !rec_ready;
    prev_data  = rec_data_o;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog all requirements actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seen;
    for (int i = 0; i < 4; i++) tgt[i] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rec_valid_o == 1'b0, "R1 valid after reset", rec_valid_o, 0);
    check(conv_busy_o == 1'b0, "R1 busy after reset", conv_busy_o, 0);

    // held, re-armed and gain-switched hits
    cur_tag = "R4,R5,R7,R9";
    tgt[0] = 10; tgt[1] = 0; tgt[2] = 37; tgt[3] = 3;
    drive(0, 0, 0, 1, 0);
    bunch(0, 1, 3, 0);
    bunch(1, 0, 0, 0);
    bunch(1, 0, 4, 1);
    bunch(1, 0, 4, 1);
    bunch(1, 2, 1, 0);
    drive(0, 0, 0, 0, 1);
    drain("R7");

    // six hits into four slots, saturation edges, hits after end
    cur_tag = "R6";
    tgt[0] = 8191; tgt[1] = 9000; tgt[2] = 5; tgt[3] = 1;
    drive(0, 0, 0, 1, 0);
    for (int b = 0; b < 6; b++) bunch(1, 1, 2, b[0]);
    drive(0, 0, 0, 0, 1);
    drive(0, 1, 1, 0, 0);
    drive(0, 1, 1, 0, 0);
    drain("R6");

    // empty train with a hit in the end cycle
    cur_tag = "R10";
    seen = rec_count;
    drive(0, 0, 0, 1, 0);
    bunch(1, 0, 0, 0);
    bunch(1, 0, 0, 0);
    drive(0, 1, 0, 0, 1);
    drain("R10");
    check(rec_count == seen, "R10 no record for empty train", rec_count, seen);

    // hit in start cycle dropped, hit in tick cycle, counter saturation
    cur_tag = "R2,R3";
    tgt[0] = 2; tgt[1] = 4;
    drive(0, 1, 0, 1, 0);
    drive(0, 0, 0, 0, 0);
    bunch(1, 0, 1, 1);
    for (int i = 0; i < 4100; i++) drive(1, 0, 0, 0, 0);
    bunch(0, 1, 1, 0);
    drive(0, 0, 0, 0, 1);
    drain("R3");

    // abort of conversion by a new train
    cur_tag = "R2";
    tgt[0] = 500;
    seen = rec_count;
    drive(0, 0, 0, 1, 0);
    bunch(1, 0, 1, 0);
    drive(0, 0, 0, 0, 1);
    repeat (5) drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0);
    check(conv_busy_o == 1'b0, "R2 conversion stopped by start", conv_busy_o, 0);
    drive(0, 0, 0, 0, 1);
    drain("R2");
    check(rec_count == seen, "R2 aborted slot not emitted", rec_count, seen);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule